// File: doc/BRIEF.md
# Debug Exception Cause Controller

This block sits beside a processor pipeline and decides, one retiring instruction at a time, whether that instruction enters the debug exception. Five event sources can request the exception. Two come from inside the block: a set of instruction-address breakpoint comparators with their enable bits, and an instruction counter that expires on overflow. Three are strobes from the pipeline: a data-breakpoint hit with the index of the matching comparator, a wide break instruction and a narrow break instruction.

An instruction can request the exception at any time, but the exception is only taken while the current interrupt level is below the debug level, which is 6. When it is taken, the block raises a one-cycle vector-take strobe and a one-cycle pipeline flush request. In that same cycle it updates three values:
- the saved PC, which holds the address of the instruction that caused the exception;
- the low five bits of the new processor status, which set the exception-mode bit and the debug interrupt level;
- a one-hot cause word that names the winning source.

The comparator addresses, the comparator enables, the counter value and the count level are loaded through simple write strobes. When a write and an update of the same register occur in the same cycle, the write wins.

Top module: `dbg_exc_ctrl`

## Requirements
- R1: A synchronous reset clears every breakpoint enable bit, the count level, the counter, the cause word, the saved PC and the status output, and holds `take_o` and `flush_o` low.
- R2: A wide break instruction retired at an interrupt level below 6 takes the exception and reports cause 0x008 one cycle later.
- R3: A narrow break instruction retired at an interrupt level below 6 takes the exception and reports cause 0x010.
- R4: At interrupt level 6 or above, no source takes the exception. `take_o` stays low, and the cause, saved PC and status keep their previous values.
- R5: On a taken exception, `ps_o` becomes 0x16 (bit 4 is the exception-mode bit, bits 3:0 hold level 6) and `epc_o` holds the PC of the instruction that caused it.
- R6: Comparator i fires, with cause 0x002, only when enable bit i is set and the retiring PC equals its programmed address. While enable bit i is clear, a matching PC does not fire.
- R7: A data-breakpoint hit reports bit 2 (0x004) with the comparator index in cause bits 11:8. For every other cause, bits 11:8 are zero.
- R8: The counter increments once for each retiring instruction whose interrupt level is below the count level. An instruction that increments the counter from all-ones to zero takes the exception with cause 0x001. Instructions at or above the count level do not advance the counter.
- R9: When several sources fire on one instruction, exactly one cause bit is reported. The priority is counter, then instruction breakpoint, then data breakpoint, then wide break, then narrow break.
- R10: `take_o` and `flush_o` are single-cycle pulses that rise together in the cycle after the causing instruction. A cycle without a retiring instruction never takes the exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid_i | input | 1 | An instruction retires this cycle |
| instr_pc_i | input | AW | PC of the retiring instruction |
| intlevel_i | input | 4 | Current interrupt level |
| brk_wide_i | input | 1 | Retiring instruction is a wide break |
| brk_narrow_i | input | 1 | Retiring instruction is a narrow break |
| dbrk_hit_i | input | 1 | Data breakpoint matched on this instruction |
| dbrk_idx_i | input | IDX_W | Index of the matching data comparator |
| ib_addr_we_i | input | 1 | Write a comparator address |
| ib_addr_sel_i | input | SEL_W | Comparator selected for the address write |
| ib_addr_wdata_i | input | AW | Address value to write |
| ib_en_we_i | input | 1 | Write the comparator enable bits |
| ib_en_wdata_i | input | NUM_IB | Enable bits to write |
| icnt_we_i | input | 1 | Write the counter |
| icnt_wdata_i | input | CNT_W | Counter value to write |
| icnt_lvl_we_i | input | 1 | Write the count level |
| icnt_lvl_wdata_i | input | 4 | Count level to write |
| take_o | output | 1 | Debug vector-take strobe |
| flush_o | output | 1 | Pipeline flush request |
| epc_o | output | AW | Saved PC of the causing instruction |
| ps_o | output | 5 | New low processor-status bits |
| cause_o | output | 12 | Debug cause word |

## Verification
Each break strobe is first retired alone below level 6, then retired again at level 6 and at level 7. These pairs show that the level mask, and not the decode, decides whether the exception is taken, and that the state recorded earlier survives an ignored break.

The comparators are tested with:
- a matching address with the enable set;
- the same address with the enable cleared;
- a neighbouring address.

These cases separate the enable gating from the address compare.

The counter is loaded with -2 and fed instructions both above and below the count level. This shows that only counted instructions advance it, and that the exception falls on the instruction that wraps it to zero.

Finally, stacked combinations of sources on one instruction confirm that the priority order produces a single cause bit, and that the comparator index appears only with the data cause.

// File: rtl/dbg_exc_pkg.sv
package dbg_exc_pkg;

    // Cause word layout
    localparam int CAUSE_W   = 12;
    localparam int IDX_LSB   = 8;
    localparam int LVL_W     = 4;
    localparam int PS_W      = 5;

    // Bit positions of the one-hot cause sources (the order is the priority)
    localparam int C_ICNT    = 0;
    localparam int C_IBRK    = 1;
    localparam int C_DBRK    = 2;
    localparam int C_WIDE    = 3;
    localparam int C_NARROW  = 4;
    localparam int NUM_SRC   = 5;

    // Exception-mode bit inside the status field
    localparam int PS_EXC_BIT = 4;

endpackage

// File: rtl/dbg_ibrk_unit.sv
module dbg_ibrk_unit #(
    parameter int AW    = 32,
    parameter int NUM   = 2,
    parameter int SEL_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             addr_we_i,
    input  logic [SEL_W-1:0] addr_sel_i,
    input  logic [AW-1:0]    addr_wdata_i,
    input  logic             en_we_i,
    input  logic [NUM-1:0]   en_wdata_i,
    input  logic [AW-1:0]    pc_i,
    output logic             hit_o
);

    typedef struct packed {
        logic [NUM-1:0][AW-1:0] addr;
        logic [NUM-1:0]         en;
    } ib_state_t;

    ib_state_t st_d, st_q;
    logic [NUM-1:0] match;

    // One comparator per breakpoint; each is gated by its own enable bit
    for (genvar gi = 0; gi < NUM; gi++) begin : g_cmp
        assign match[gi] = st_q.en[gi] && (st_q.addr[gi] == pc_i);
    end

    assign hit_o = |match;

    always_comb begin
        st_d = st_q;
        if (addr_we_i) begin
            for (int i = 0; i < NUM; i++) begin
                if (addr_sel_i == SEL_W'(i)) st_d.addr[i] = addr_wdata_i;
            end
        end
        if (en_we_i) st_d.en = en_wdata_i;
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R6
    en_off_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (en_we_i && en_wdata_i == '0) |=> !hit_o);

endmodule

// File: rtl/dbg_icnt_unit.sv
module dbg_icnt_unit
    import dbg_exc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic             cnt_we_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic             lvl_we_i,
    input  logic [LVL_W-1:0] lvl_wdata_i,
    output logic             expire_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [LVL_W-1:0] lvl;
    } ic_state_t;

    ic_state_t st_d, st_q;
    logic      inc;

    // An instruction is counted only below the programmed count level
    assign inc      = valid_i && (level_i < st_q.lvl);
    assign expire_o = inc && (&st_q.cnt);

    always_comb begin
        st_d = st_q;
        if (inc) st_d.cnt = st_q.cnt + CNT_W'(1);
        if (cnt_we_i) st_d.cnt = cnt_wdata_i;
        if (lvl_we_i) st_d.lvl = lvl_wdata_i;
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R8
    icnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && (&st_q.cnt) && !cnt_we_i) |=> (st_q.cnt == '0));

    // R8
    icnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!inc && !cnt_we_i) |=> $stable(st_q.cnt));

endmodule

// File: rtl/dbg_cause_arb.sv
module dbg_cause_arb
    import dbg_exc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [IDX_W-1:0]   dbrk_idx_i,
    output logic               any_o,
    output logic [CAUSE_W-1:0] cause_o
);

    assign any_o = |req_i;

    // Lowest bit position wins; only the data cause carries the index field
    always_comb begin
        cause_o = '0;
        if (req_i[C_ICNT]) begin
            cause_o[C_ICNT] = 1'b1;
        end else if (req_i[C_IBRK]) begin
            cause_o[C_IBRK] = 1'b1;
        end else if (req_i[C_DBRK]) begin
            cause_o[C_DBRK] = 1'b1;
            cause_o[IDX_LSB +: IDX_W] = dbrk_idx_i;
        end else if (req_i[C_WIDE]) begin
            cause_o[C_WIDE] = 1'b1;
        end else if (req_i[C_NARROW]) begin
            cause_o[C_NARROW] = 1'b1;
        end
    end

endmodule

// File: rtl/dbg_exc_ctrl.sv
module dbg_exc_ctrl
    import dbg_exc_pkg::*;
#(
    parameter int AW        = 32,
    parameter int NUM_IB    = 2,
    parameter int CNT_W     = 32,
    parameter int IDX_W     = 4,
    parameter int DBG_LEVEL = 6,
    parameter int SEL_W     = (NUM_IB > 1) ? $clog2(NUM_IB) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid_i,
    input  logic [AW-1:0]      instr_pc_i,
    input  logic [LVL_W-1:0]   intlevel_i,
    input  logic               brk_wide_i,
    input  logic               brk_narrow_i,
    input  logic               dbrk_hit_i,
    input  logic [IDX_W-1:0]   dbrk_idx_i,
    input  logic               ib_addr_we_i,
    input  logic [SEL_W-1:0]   ib_addr_sel_i,
    input  logic [AW-1:0]      ib_addr_wdata_i,
    input  logic               ib_en_we_i,
    input  logic [NUM_IB-1:0]  ib_en_wdata_i,
    input  logic               icnt_we_i,
    input  logic [CNT_W-1:0]   icnt_wdata_i,
    input  logic               icnt_lvl_we_i,
    input  logic [LVL_W-1:0]   icnt_lvl_wdata_i,
    output logic               take_o,
    output logic               flush_o,
    output logic [AW-1:0]      epc_o,
    output logic [PS_W-1:0]    ps_o,
    output logic [CAUSE_W-1:0] cause_o
);

    localparam logic [LVL_W-1:0] LVL_DBG  = LVL_W'(DBG_LEVEL);
    localparam logic [PS_W-1:0]  PS_ENTRY = PS_W'((1 << PS_EXC_BIT) | DBG_LEVEL);

    typedef struct packed {
        logic               take;
        logic               flush;
        logic [AW-1:0]      epc;
        logic [PS_W-1:0]    ps;
        logic [CAUSE_W-1:0] cause;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic               ib_hit;
    logic               cnt_expire;
    logic [NUM_SRC-1:0] req;
    logic               req_any;
    logic [CAUSE_W-1:0] arb_cause;
    logic               lvl_open;

    dbg_ibrk_unit #(.AW(AW), .NUM(NUM_IB), .SEL_W(SEL_W)) ibrk_i (
        .clk          (clk),
        .rst          (rst),
        .addr_we_i    (ib_addr_we_i),
        .addr_sel_i   (ib_addr_sel_i),
        .addr_wdata_i (ib_addr_wdata_i),
        .en_we_i      (ib_en_we_i),
        .en_wdata_i   (ib_en_wdata_i),
        .pc_i         (instr_pc_i),
        .hit_o        (ib_hit)
    );

    dbg_icnt_unit #(.CNT_W(CNT_W)) icnt_i (
        .clk         (clk),
        .rst         (rst),
        .valid_i     (instr_valid_i),
        .level_i     (intlevel_i),
        .cnt_we_i    (icnt_we_i),
        .cnt_wdata_i (icnt_wdata_i),
        .lvl_we_i    (icnt_lvl_we_i),
        .lvl_wdata_i (icnt_lvl_wdata_i),
        .expire_o    (cnt_expire)
    );

    always_comb begin
        req           = '0;
        req[C_ICNT]   = cnt_expire;
        req[C_IBRK]   = ib_hit;
        req[C_DBRK]   = dbrk_hit_i;
        req[C_WIDE]   = brk_wide_i;
        req[C_NARROW] = brk_narrow_i;
    end

    dbg_cause_arb #(.IDX_W(IDX_W)) arb_i (
        .req_i      (req),
        .dbrk_idx_i (dbrk_idx_i),
        .any_o      (req_any),
        .cause_o    (arb_cause)
    );

    // The debug level masks every source
    assign lvl_open = instr_valid_i && (intlevel_i < LVL_DBG);

    always_comb begin
        st_d       = st_q;
        st_d.take  = 1'b0;
        st_d.flush = 1'b0;
        if (lvl_open && req_any) begin
            st_d.take  = 1'b1;
            st_d.flush = 1'b1;
            st_d.epc   = instr_pc_i;
            st_d.ps    = PS_ENTRY;
            st_d.cause = arb_cause;
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign take_o  = st_q.take;
    assign flush_o = st_q.flush;
    assign epc_o   = st_q.epc;
    assign ps_o    = st_q.ps;
    assign cause_o = st_q.cause;

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!take_o && !flush_o && cause_o == '0 && ps_o == '0));

    // R4
    lvl_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid_i && intlevel_i >= LVL_DBG) |=> !take_o);

    // R4
    cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !take_o |-> ($stable(cause_o) && $stable(epc_o)));

    // R5
    ps_entry_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (ps_o == PS_ENTRY));

    // R5
    epc_capture_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (epc_o == $past(instr_pc_i)));

    // R9
    cause_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $onehot(cause_o[NUM_SRC-1:0]));

    // R7
    idx_field_chk: assert property (@(posedge clk) disable iff (rst)
        (take_o && !cause_o[C_DBRK]) |-> (cause_o[CAUSE_W-1:IDX_LSB] == '0));

    // R10
    flush_pair_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> flush_o);

    // R10
    no_instr_no_take_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_valid_i |=> !take_o);

endmodule

// File: tb/dbg_exc_ctrl_tb.sv
module dbg_exc_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_pc = '0;
    logic [3:0]  intlevel = '0;
    logic        brk_wide = 1'b0;
    logic        brk_narrow = 1'b0;
    logic        dbrk_hit = 1'b0;
    logic [3:0]  dbrk_idx = '0;
    logic        ib_addr_we = 1'b0;
    logic [0:0]  ib_addr_sel = '0;
    logic [31:0] ib_addr_wdata = '0;
    logic        ib_en_we = 1'b0;
    logic [1:0]  ib_en_wdata = '0;
    logic        icnt_we = 1'b0;
    logic [31:0] icnt_wdata = '0;
    logic        icnt_lvl_we = 1'b0;
    logic [3:0]  icnt_lvl_wdata = '0;
    logic        take, flush;
    logic [31:0] epc;
    logic [4:0]  ps;
    logic [11:0] cause;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dbg_exc_ctrl dut_i (
        .clk(clk), .rst(rst),
        .instr_valid_i(instr_valid), .instr_pc_i(instr_pc), .intlevel_i(intlevel),
        .brk_wide_i(brk_wide), .brk_narrow_i(brk_narrow),
        .dbrk_hit_i(dbrk_hit), .dbrk_idx_i(dbrk_idx),
        .ib_addr_we_i(ib_addr_we), .ib_addr_sel_i(ib_addr_sel), .ib_addr_wdata_i(ib_addr_wdata),
        .ib_en_we_i(ib_en_we), .ib_en_wdata_i(ib_en_wdata),
        .icnt_we_i(icnt_we), .icnt_wdata_i(icnt_wdata),
        .icnt_lvl_we_i(icnt_lvl_we), .icnt_lvl_wdata_i(icnt_lvl_wdata),
        .take_o(take), .flush_o(flush), .epc_o(epc), .ps_o(ps), .cause_o(cause)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Retire one instruction at a negedge; outputs are valid at the following negedge
    task automatic retire(input logic [31:0] pc, input logic [3:0] lvl,
                          input logic w, input logic n, input logic d, input logic [3:0] idx);
        instr_valid = 1'b1; instr_pc = pc; intlevel = lvl;
        brk_wide = w; brk_narrow = n; dbrk_hit = d; dbrk_idx = idx;
        @(negedge clk);
        instr_valid = 1'b0; brk_wide = 1'b0; brk_narrow = 1'b0; dbrk_hit = 1'b0;
    endtask

    // Expect a taken exception with the given cause and PC
    task automatic expect_take(input string req, input logic [11:0] c, input logic [31:0] pc);
        chk({req, " take"}, take, 1);
        chk({req, " flush"}, flush, 1);
        chk({req, " cause"}, cause, c);
        chk({req, " epc"}, epc, pc);
        chk({req, " ps"}, ps, 5'h16);
    endtask

    task automatic wr_ib(input logic sel, input logic [31:0] a, input logic [1:0] en);
        ib_addr_we = 1'b1; ib_addr_sel = sel; ib_addr_wdata = a;
        ib_en_we = 1'b1; ib_en_wdata = en;
        @(negedge clk);
        ib_addr_we = 1'b0; ib_en_we = 1'b0;
    endtask

    task automatic wr_cnt(input logic [31:0] v, input logic [3:0] lvl);
        icnt_we = 1'b1; icnt_wdata = v; icnt_lvl_we = 1'b1; icnt_lvl_wdata = lvl;
        @(negedge clk);
        icnt_we = 1'b0; icnt_lvl_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 take", take, 0);
        chk("R1 flush", flush, 0);
        chk("R1 cause", cause, 0);
        chk("R1 ps", ps, 0);
        chk("R1 epc", epc, 0);
        // enables and count level cleared: matching PC 0 at level 0 does not fire
        retire(32'h0, 4'd0, 0, 0, 0, 0);
        chk("R1 no source after reset", take, 0);
    endtask

    task automatic t_breaks();
        retire(32'h1000, 4'd5, 1, 0, 0, 0);
        expect_take("R2", 12'h008, 32'h1000);
        @(negedge clk);
        chk("R10 take pulse ends", take, 0);
        chk("R10 flush pulse ends", flush, 0);
        retire(32'h1004, 4'd0, 0, 1, 0, 0);
        expect_take("R3", 12'h010, 32'h1004);
    endtask

    task automatic t_level_mask();
        retire(32'h2000, 4'd6, 1, 0, 0, 0);
        chk("R4 level 6 wide ignored", take, 0);
        chk("R4 cause kept", cause, 12'h010);
        chk("R4 epc kept", epc, 32'h1004);
        retire(32'h2004, 4'd7, 0, 1, 1, 4'd3);
        chk("R4 level 7 ignored", take, 0);
        chk("R4 cause still kept", cause, 12'h010);
    endtask

    task automatic t_ibreak();
        wr_ib(1'b0, 32'h100, 2'b01);
        retire(32'h104, 4'd5, 0, 0, 0, 0);
        chk("R6 other address", take, 0);
        retire(32'h100, 4'd5, 0, 0, 0, 0);
        expect_take("R6 comparator 0", 12'h002, 32'h100);
        wr_ib(1'b1, 32'h200, 2'b10);
        retire(32'h100, 4'd5, 0, 0, 0, 0);
        chk("R6 disabled comparator 0", take, 0);
        retire(32'h200, 4'd2, 0, 0, 0, 0);
        expect_take("R6 comparator 1", 12'h002, 32'h200);
        wr_ib(1'b0, 32'h100, 2'b00);
        retire(32'h200, 4'd2, 0, 0, 0, 0);
        chk("R6 all disabled", take, 0);
        chk("R6 cause kept", cause, 12'h002);
    endtask

    task automatic t_dbreak();
        retire(32'h3000, 4'd5, 0, 0, 1, 4'd1);
        expect_take("R7 index 1", 12'h104, 32'h3000);
        retire(32'h3004, 4'd1, 0, 0, 1, 4'd0);
        expect_take("R7 index 0", 12'h004, 32'h3004);
    endtask

    task automatic t_icount();
        wr_cnt(32'hFFFF_FFFE, 4'd1);
        retire(32'h4000, 4'd5, 0, 0, 0, 0);
        chk("R8 above count level not counted", take, 0);
        retire(32'h4004, 4'd0, 0, 0, 0, 0);
        chk("R8 first count no expiry", take, 0);
        retire(32'h4008, 4'd0, 0, 0, 0, 0);
        expect_take("R8 expiry", 12'h001, 32'h4008);
        retire(32'h400c, 4'd0, 0, 0, 0, 0);
        chk("R8 counter wrapped to zero", take, 0);
        wr_cnt(32'h0, 4'd0);
    endtask

    task automatic t_priority();
        wr_ib(1'b0, 32'h500, 2'b01);
        retire(32'h500, 4'd5, 1, 0, 0, 0);
        expect_take("R9 ibreak over wide", 12'h002, 32'h500);
        retire(32'h500, 4'd5, 1, 1, 1, 4'd2);
        expect_take("R9 ibreak over dbreak", 12'h002, 32'h500);
        retire(32'h504, 4'd5, 1, 1, 1, 4'd2);
        expect_take("R9 dbreak over breaks", 12'h204, 32'h504);
        retire(32'h508, 4'd5, 1, 1, 0, 4'd2);
        expect_take("R9 wide over narrow", 12'h008, 32'h508);
        wr_cnt(32'hFFFF_FFFF, 4'd8);
        retire(32'h500, 4'd3, 1, 1, 1, 4'd5);
        expect_take("R9 counter over all", 12'h001, 32'h500);
        wr_cnt(32'h0, 4'd0);
        wr_ib(1'b0, 32'h0, 2'b00);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_breaks();
        t_level_mask();
        t_ibreak();
        t_dbreak();
        t_icount();
        t_priority();
        @(negedge clk);
        chk("R10 idle no take", take, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule